// File: doc/BRIEF.md
# Packed SIMD Integer Vector ALU

This block is a single-cycle integer vector ALU for a 512-bit datapath. Each issue carries two source vectors, an 8-bit opcode, a copy of the destination's current contents and a per-lane guard mask. The opcode selects the element width, the operation and its variant. The vector is split into 64 byte lanes, 32 halfword lanes or 16 word lanes, and every lane is computed on its own with no carry or borrow crossing a lane boundary.

The operations are add, subtract, negate, absolute value, absolute difference, min and max. Signed, unsigned, saturating and guarded behaviour are not mode bits. Each combination of operation, width, variant and guarding is its own opcode value. The result and a valid strobe are registered one clock after issue. An opcode with no defined meaning yields an all-zero vector and raises an illegal flag for that one result cycle.

Top module: `simd_vec_alu`

## Requirements
- R1: opcode[6:5] selects the element width: 0 = 8-bit (64 lanes), 1 = 16-bit (32 lanes), 2 = 32-bit (16 lanes). Lane k occupies bits [k*w +: w], and no carry or borrow crosses from one lane into the next.
- R2: opcode[4:0] selects the operation: 0 add, 1 saturating add, 2 sub, 3 saturating sub, 4 negate, 5 saturating negate, 6 abs, 7 saturating abs, 8 signed |a-b|, 9 unsigned |a-b|, 10 saturating signed |a-b|, 11 signed min, 12 unsigned min, 13 signed max, 14 unsigned max. opcode[7] set makes the operation guarded.
- R3: Plain add and subtract wrap modulo 2^w.
- R4: Plain negate and abs wrap modulo 2^w, so the most negative value maps to itself.
- R5: Saturating add and subtract clamp to [-2^(w-1), 2^(w-1)-1]. For 16-bit lanes this is [-32768, 32767].
- R6: Saturating negate and abs map the most negative value to the most positive value. For 16-bit lanes, -32768 becomes 32767.
- R7: Signed |a-b| returns the low w bits of the exact magnitude. The saturating form clamps that magnitude to 2^(w-1)-1.
- R8: Unsigned |a-b| treats both lanes as unsigned and returns the exact magnitude.
- R9: Min and max compare as two's-complement values in the signed forms and as unsigned values in the unsigned forms.
- R10: In a guarded operation, a lane whose guard bit k is clear takes lane k of old_dst_i, and a lane whose guard bit is set takes the computed value. Unguarded operations ignore the guard mask.
- R11: Width code 3, operation codes 15 to 31, and the |a-b| codes 8 to 10 at 32-bit width are illegal. An illegal issue yields an all-zero result and raises illegal_o with valid_o for one cycle.
- R12: result_o and valid_o appear on the clock edge after an issue. Without an issue, valid_o is low and result_o holds its value.
- R13: During reset, result_o is zero and valid_o and illegal_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Operation is presented this cycle |
| opcode_i | input | 8 | Guard flag, width code and operation code |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| old_dst_i | input | 512 | Current destination contents, kept in unguarded-off lanes |
| guard_i | input | 64 | Per-lane guard; bit k guards lane k |
| result_o | output | 512 | Registered result vector |
| valid_o | output | 1 | Result is new this cycle |
| illegal_o | output | 1 | Issued opcode was undefined |

## Verification
The hardest condition to reach from the ports is every extreme operand pair meeting every operation in the same lane geometry, for example the most negative value against the most positive, or -1 against zero. Random data almost never produces these pairs. The stimulus therefore builds vectors in which consecutive lanes walk through all sixteen pairings of zero, minus one, minimum and maximum. It sends each of these vectors through every operation at every width and compares every lane against a behavioural model. Lane isolation is reached with all-ones lanes plus one, and guarding is reached with sparse and dense guard patterns that also set guard bits beyond the lane count.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int OPC_W   = 8;
    localparam int KIND_W  = 5;
    localparam int NUM_EW  = 3;

    typedef enum logic [KIND_W-1:0] {
        K_ADD   = 5'd0,
        K_ADDS  = 5'd1,
        K_SUB   = 5'd2,
        K_SUBS  = 5'd3,
        K_NEG   = 5'd4,
        K_NEGS  = 5'd5,
        K_ABS   = 5'd6,
        K_ABSS  = 5'd7,
        K_ADIF  = 5'd8,
        K_ADIFU = 5'd9,
        K_ADIFS = 5'd10,
        K_MIN   = 5'd11,
        K_MINU  = 5'd12,
        K_MAX   = 5'd13,
        K_MAXU  = 5'd14
    } alu_kind_e;

    localparam logic [KIND_W-1:0] KIND_LAST = 5'd14;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2
    } elem_w_e;

    typedef struct packed {
        logic      legal;
        logic      guarded;
        elem_w_e   ew;
        alu_kind_e kind;
    } alu_ctl_t;

    function automatic logic kind_is_absdiff(input logic [KIND_W-1:0] k);
        return (k == K_ADIF) || (k == K_ADIFU) || (k == K_ADIFS);
    endfunction

endpackage

// File: rtl/simd_alu_decode.sv
module simd_alu_decode
    import simd_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output alu_ctl_t         ctl_o
);
    logic [KIND_W-1:0] raw_kind;
    logic [1:0]        raw_w;
    logic              kind_ok;
    logic              width_ok;
    logic              wide_absdiff;

    always_comb begin
        raw_kind     = opcode_i[KIND_W-1:0];
        raw_w        = opcode_i[6:5];
        kind_ok      = (raw_kind <= KIND_LAST);
        width_ok     = (raw_w != 2'd3);
        wide_absdiff = (raw_w == EW32) && kind_is_absdiff(raw_kind);

        ctl_o.legal   = kind_ok && width_ok && !wide_absdiff;
        ctl_o.guarded = opcode_i[7];
        ctl_o.ew      = width_ok ? elem_w_e'(raw_w) : EW8;
        ctl_o.kind    = kind_ok ? alu_kind_e'(raw_kind) : K_ADD;
    end
endmodule

// File: rtl/simd_alu_lane.sv
module simd_alu_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_kind_e    kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   ax, bx;
    logic [W:0]   sum_x, dif_x, neg_x, abs_x, mag_x;
    logic [W:0]   udif_x;
    logic [W-1:0] umag;
    logic         s_lt, u_lt;

    function automatic logic [W-1:0] clamp_s(input logic [W:0] v);
        if (v[W] != v[W-1]) return v[W] ? SMIN : SMAX;
        return v[W-1:0];
    endfunction

    always_comb begin
        ax     = {a_i[W-1], a_i};
        bx     = {b_i[W-1], b_i};
        sum_x  = ax + bx;
        dif_x  = ax - bx;
        neg_x  = '0 - ax;
        abs_x  = a_i[W-1] ? neg_x : ax;
        mag_x  = dif_x[W] ? ('0 - dif_x) : dif_x;
        udif_x = {1'b0, a_i} - {1'b0, b_i};
        umag   = udif_x[W] ? (b_i - a_i) : udif_x[W-1:0];
        s_lt   = $signed(a_i) < $signed(b_i);
        u_lt   = a_i < b_i;

        unique case (kind_i)
            K_ADD:   y_o = sum_x[W-1:0];
            K_ADDS:  y_o = clamp_s(sum_x);
            K_SUB:   y_o = dif_x[W-1:0];
            K_SUBS:  y_o = clamp_s(dif_x);
            K_NEG:   y_o = neg_x[W-1:0];
            K_NEGS:  y_o = clamp_s(neg_x);
            K_ABS:   y_o = abs_x[W-1:0];
            K_ABSS:  y_o = clamp_s(abs_x);
            K_ADIF:  y_o = mag_x[W-1:0];
            K_ADIFU: y_o = umag;
            K_ADIFS: y_o = (mag_x[W] | mag_x[W-1]) ? SMAX : mag_x[W-1:0];
            K_MIN:   y_o = s_lt ? a_i : b_i;
            K_MINU:  y_o = u_lt ? a_i : b_i;
            K_MAX:   y_o = s_lt ? b_i : a_i;
            K_MAXU:  y_o = u_lt ? b_i : a_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/simd_alu_lane_array.sv
module simd_alu_lane_array
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 512,
    parameter int W     = 16,
    localparam int LANES = VEC_W / W
) (
    input  alu_kind_e        kind_i,
    input  logic             guarded_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [VEC_W-1:0] old_i,
    input  logic [LANES-1:0] guard_i,
    output logic [VEC_W-1:0] y_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] calc;

        simd_alu_lane #(.W(W)) lane_i (
            .kind_i (kind_i),
            .a_i    (a_i[i*W +: W]),
            .b_i    (b_i[i*W +: W]),
            .y_o    (calc)
        );

        assign y_o[i*W +: W] = (guarded_i && !guard_i[i]) ? old_i[i*W +: W] : calc;
    end
endmodule

// File: rtl/simd_vec_alu.sv
module simd_vec_alu
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 512,
    localparam int GUARD_W = VEC_W / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [VEC_W-1:0]   src_a_i,
    input  logic [VEC_W-1:0]   src_b_i,
    input  logic [VEC_W-1:0]   old_dst_i,
    input  logic [GUARD_W-1:0] guard_i,
    output logic [VEC_W-1:0]   result_o,
    output logic               valid_o,
    output logic               illegal_o
);
    alu_ctl_t         ctl;
    logic [VEC_W-1:0] grp_res [NUM_EW];
    logic [VEC_W-1:0] next_res;

    simd_alu_decode dec_i (
        .opcode_i (opcode_i),
        .ctl_o    (ctl)
    );

    for (genvar g = 0; g < NUM_EW; g++) begin : g_width
        localparam int EW_BITS = 8 << g;
        localparam int EW_LN   = VEC_W / EW_BITS;

        simd_alu_lane_array #(.VEC_W(VEC_W), .W(EW_BITS)) arr_i (
            .kind_i    (ctl.kind),
            .guarded_i (ctl.guarded),
            .a_i       (src_a_i),
            .b_i       (src_b_i),
            .old_i     (old_dst_i),
            .guard_i   (guard_i[EW_LN-1:0]),
            .y_o       (grp_res[g])
        );
    end

    always_comb begin
        unique case (ctl.ew)
            EW8:     next_res = grp_res[0];
            EW16:    next_res = grp_res[1];
            EW32:    next_res = grp_res[2];
            default: next_res = '0;
        endcase
        if (!ctl.legal) next_res = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            valid_o   <= issue_i;
            illegal_o <= issue_i && !ctl.legal;
            if (issue_i) result_o <= next_res;
        end
    end
endmodule

// File: rtl/simd_vec_alu_chk.sv
module simd_vec_alu_chk #(
    parameter int VEC_W = 512,
    localparam int GUARD_W = VEC_W / 8
) (
    input logic               clk,
    input logic               rst,
    input logic               issue_i,
    input logic [7:0]         opcode_i,
    input logic [VEC_W-1:0]   old_dst_i,
    input logic [GUARD_W-1:0] guard_i,
    input logic [VEC_W-1:0]   result_o,
    input logic               valid_o,
    input logic               illegal_o
);
    assert_valid_follows_issue_R12: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> valid_o);

    assert_idle_no_valid_R12: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> !valid_o);

    assert_idle_holds_result_R12: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> $stable(result_o));

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (valid_o && result_o == '0));

    assert_bad_width_flagged_R11: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i[6:5] == 2'b11) |=> illegal_o);

    assert_guard_off_keeps_old_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i[7] && guard_i == '0) |=> (illegal_o || result_o == $past(old_dst_i)));

    assert_reset_quiet_R13: assert property (@(posedge clk)
        rst |=> (!valid_o && !illegal_o && result_o == '0));
endmodule

bind simd_vec_alu simd_vec_alu_chk #(.VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .issue_i   (issue_i),
    .opcode_i  (opcode_i),
    .old_dst_i (old_dst_i),
    .guard_i   (guard_i),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
);

// File: tb/simd_vec_alu_tb_top.sv
module simd_vec_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 512;
    localparam int GW = VW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue = 1'b0;
    logic [7:0]    opcode = '0;
    logic [VW-1:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [GW-1:0] guard = '0;
    logic [VW-1:0] result;
    logic          valid, illegal;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_vec_alu dut_i (
        .clk (clk), .rst (rst), .issue_i (issue), .opcode_i (opcode),
        .src_a_i (src_a), .src_b_i (src_b), .old_dst_i (old_dst), .guard_i (guard),
        .result_o (result), .valid_o (valid), .illegal_o (illegal)
    );

    function automatic logic [7:0] mk_op(input int g, input int ws, input int k);
        return {g[0], ws[1:0], k[4:0]};
    endfunction

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [VW-1:0] ref_calc(input logic [7:0] op, input logic [VW-1:0] a,
            input logic [VW-1:0] b, input logic [VW-1:0] old, input logic [GW-1:0] g,
            output logic bad);
        int ws, k, w;
        longint mask, smax, smin;
        logic [VW-1:0] res, t;
        ws = int'(op[6:5]);
        k  = int'(op[4:0]);
        bad = (ws == 3) || (k > 14) || (ws == 2 && k >= 8 && k <= 10);
        res = '0;
        if (bad) return res;
        w = 8 << ws;
        mask = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w-1)) - 1;
        smin = -(longint'(1) << (w-1));
        for (int i = 0; i < VW / w; i++) begin
            longint ua, ub, sa, sb, r;
            t  = (a >> (i*w)) & {{(VW-64){1'b0}}, mask};
            ua = longint'(t[63:0]);
            t  = (b >> (i*w)) & {{(VW-64){1'b0}}, mask};
            ub = longint'(t[63:0]);
            sa = (ua > smax) ? ua - (longint'(1) << w) : ua;
            sb = (ub > smax) ? ub - (longint'(1) << w) : ub;
            case (k)
                0:  r = sa + sb;
                1:  r = clampv(sa + sb, smin, smax);
                2:  r = sa - sb;
                3:  r = clampv(sa - sb, smin, smax);
                4:  r = -sa;
                5:  r = clampv(-sa, smin, smax);
                6:  r = (sa < 0) ? -sa : sa;
                7:  r = clampv((sa < 0) ? -sa : sa, smin, smax);
                8:  r = (sa > sb) ? sa - sb : sb - sa;
                9:  r = (ua > ub) ? ua - ub : ub - ua;
                10: r = clampv((sa > sb) ? sa - sb : sb - sa, smin, smax);
                11: r = (sa < sb) ? sa : sb;
                12: r = (ua < ub) ? ua : ub;
                13: r = (sa < sb) ? sb : sa;
                default: r = (ua < ub) ? ub : ua;
            endcase
            r = r & mask;
            if (op[7] && !g[i]) begin
                t = (old >> (i*w)) & {{(VW-64){1'b0}}, mask};
                r = longint'(t[63:0]);
            end
            res = res | ({{(VW-64){1'b0}}, r} << (i*w));
        end
        return res;
    endfunction

    // lane i gets corner[(i>>sh) % 4]: 0, -1, min, max
    function automatic logic [VW-1:0] corner_fill(input int ws, input int sh);
        int w;
        longint c [4];
        logic [VW-1:0] v;
        w = 8 << ws;
        c[0] = 0;
        c[1] = (longint'(1) << w) - 1;
        c[2] = longint'(1) << (w-1);
        c[3] = (longint'(1) << (w-1)) - 1;
        v = '0;
        for (int i = 0; i < VW / w; i++)
            v = v | ({{(VW-64){1'b0}}, c[(i >> sh) % 4]} << (i*w));
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [7:0] op, input logic [VW-1:0] a,
            input logic [VW-1:0] b, input logic [VW-1:0] old, input logic [GW-1:0] g);
        logic [VW-1:0] exp;
        logic bad;
        exp = ref_calc(op, a, b, old, g, bad);
        @(negedge clk);
        issue = 1'b1; opcode = op; src_a = a; src_b = b; old_dst = old; guard = g;
        @(negedge clk);
        issue = 1'b0;
        check_vec(req, result, exp);
        check_bit(req, "illegal", illegal, bad);
        check_bit(req, "valid", valid, 1'b1);
    endtask

    task automatic run_corners(input string req, input int ws, input int k);
        run_op(req, mk_op(0, ws, k), corner_fill(ws, 0), corner_fill(ws, 2), '0, '0);
    endtask

    task automatic t_reset();
        check_vec("R13", result, '0);
        check_bit("R13", "valid", valid, 1'b0);
        check_bit("R13", "illegal", illegal, 1'b0);
    endtask

    task automatic t_wrap_add_sub();
        logic [VW-1:0] ones;
        ones = '1;
        for (int ws = 0; ws < 3; ws++) begin
            run_corners("R3", ws, 0);
            run_corners("R3", ws, 2);
        end
        // R1: all-ones lanes plus one give zero lanes; no carry escapes
        for (int ws = 0; ws < 3; ws++) begin
            logic [VW-1:0] one_v;
            one_v = '0;
            for (int i = 0; i < VW / (8 << ws); i++) one_v[i*(8 << ws)] = 1'b1;
            run_op("R1", mk_op(0, ws, 0), ones, one_v, '0, '0);
            check_vec("R1", result, '0);
            run_op("R1", mk_op(0, ws, 2), '0, one_v, '0, '0);
            check_vec("R1", result, ones);
        end
    endtask

    task automatic t_neg_abs_wrap();
        for (int ws = 0; ws < 3; ws++) begin
            run_corners("R4", ws, 4);
            run_corners("R4", ws, 6);
        end
        run_op("R4", mk_op(0, 1, 6), {32{16'h8000}}, '0, '0, '0);
        check_vec("R4", result, {32{16'h8000}});
    endtask

    task automatic t_sat_add_sub();
        for (int ws = 0; ws < 3; ws++) begin
            run_corners("R5", ws, 1);
            run_corners("R5", ws, 3);
        end
        run_op("R5", mk_op(0, 1, 1), {32{16'h7FFF}}, {32{16'h0001}}, '0, '0);
        check_vec("R5", result, {32{16'h7FFF}});
        run_op("R5", mk_op(0, 1, 3), {32{16'h8000}}, {32{16'h0001}}, '0, '0);
        check_vec("R5", result, {32{16'h8000}});
    endtask

    task automatic t_sat_neg_abs();
        for (int ws = 0; ws < 3; ws++) begin
            run_corners("R6", ws, 5);
            run_corners("R6", ws, 7);
        end
        run_op("R6", mk_op(0, 1, 5), {32{16'h8000}}, '0, '0, '0);
        check_vec("R6", result, {32{16'h7FFF}});
    endtask

    task automatic t_absdiff();
        for (int ws = 0; ws < 2; ws++) begin
            run_corners("R7", ws, 8);
            run_corners("R7", ws, 10);
            run_corners("R8", ws, 9);
        end
        run_op("R7", mk_op(0, 1, 10), {32{16'h7FFF}}, {32{16'h8000}}, '0, '0);
        check_vec("R7", result, {32{16'h7FFF}});
        run_op("R8", mk_op(0, 0, 9), {64{8'h01}}, {64{8'hFF}}, '0, '0);
        check_vec("R8", result, {64{8'hFE}});
    endtask

    task automatic t_minmax();
        for (int ws = 0; ws < 3; ws++)
            for (int k = 11; k <= 14; k++) run_corners("R9", ws, k);
    endtask

    task automatic t_guard();
        for (int ws = 0; ws < 3; ws++) begin
            run_op("R10", mk_op(1, ws, 0), rand_vec(), rand_vec(), rand_vec(), {32{2'b01}});
            run_op("R10", mk_op(1, ws, 13), rand_vec(), rand_vec(), rand_vec(), 64'hF0F0_0000_FFFF_1234);
            run_op("R10", mk_op(1, ws, 5), corner_fill(ws, 0), '0, rand_vec(), '1);
        end
        run_op("R10", mk_op(1, 2, 2), rand_vec(), rand_vec(), {16{32'hCAFE_F00D}}, 64'hFFFF_FFFF_FFFF_0000);
        check_vec("R10", result, {16{32'hCAFE_F00D}});
        run_op("R10", mk_op(0, 1, 0), rand_vec(), rand_vec(), rand_vec(), '0);
    endtask

    task automatic t_illegal();
        run_op("R11", mk_op(0, 3, 0), rand_vec(), rand_vec(), rand_vec(), '1);
        run_op("R11", mk_op(1, 1, 20), rand_vec(), rand_vec(), rand_vec(), '0);
        run_op("R11", mk_op(0, 2, 8), rand_vec(), rand_vec(), '0, '0);
        run_op("R11", mk_op(0, 2, 9), rand_vec(), rand_vec(), '0, '0);
        run_op("R11", mk_op(0, 2, 10), rand_vec(), rand_vec(), '0, '0);
        run_op("R11", mk_op(0, 0, 15), rand_vec(), rand_vec(), '0, '0);
        check_vec("R11", result, '0);
        @(negedge clk);
        check_bit("R11", "illegal after one cycle", illegal, 1'b0);
    endtask

    task automatic t_latency();
        logic [VW-1:0] a, b, exp;
        logic bad;
        a = rand_vec(); b = rand_vec();
        exp = ref_calc(mk_op(0, 0, 0), a, b, '0, '0, bad);
        run_op("R12", mk_op(0, 0, 0), a, b, '0, '0);
        @(negedge clk);
        src_a = rand_vec(); opcode = mk_op(0, 1, 2);
        check_bit("R12", "valid idle", valid, 1'b0);
        @(negedge clk);
        check_vec("R12", result, exp);
        check_bit("R12", "valid idle", valid, 1'b0);
    endtask

    task automatic t_random();
        for (int n = 0; n < 60; n++) begin
            int ws, k;
            ws = int'($urandom_range(2, 0));
            k  = int'($urandom_range(14, 0));
            if (ws == 2 && k >= 8 && k <= 10) k = 0;
            run_op("R2", mk_op(int'($urandom_range(1, 0)), ws, k),
                   rand_vec(), rand_vec(), rand_vec(), {$urandom, $urandom});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_wrap_add_sub();
        t_neg_abs_wrap();
        t_sat_add_sub();
        t_sat_neg_abs();
        t_absdiff();
        t_minmax();
        t_guard();
        t_illegal();
        t_latency();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule